// File: doc/BRIEF.md
# PID Compensator with Clamped Integral

This block is a fixed-point proportional-integral-derivative compensator for a position loop. Each accepted sample carries one signed position error. For that sample the block produces a signed 16-bit control sum and a motor command of 8 or 12 bits in offset-binary form. A proportional, an integral and a derivative product are added to form the sum. The integral runs through a 24-bit accumulator and its product is limited in magnitude. The derivative difference is taken only once every programmable number of samples, and the last derivative product is reused on the samples in between.

Errors arrive on a valid/ready stream and results leave on a second valid/ready stream. Each accepted error makes exactly one result, and the result register holds a single entry. The input is ready when that register is empty or is being drained in the same cycle. While the consumer holds `cmd_ready` low with a result pending, the input stalls and the pending result stays unchanged. The coefficients, the derivative interval and the width select are plain control pins. They are sampled in the cycle an error is accepted.

Top module: `pid_clamp_filter`

## Requirements
- R1: The 24-bit signed input error is saturated to the range -32768..32767 before any other use.
- R2: Every coefficient product (kp, ki, kd, each a signed 16-bit value) keeps only the low 16 bits of the product, read as a signed value.
- R3: On each accepted sample the saturated error is added to a 24-bit signed accumulator that saturates at -8388608 and 8388607. The updated accumulator, arithmetically shifted right by 8 bits, is the operand of the ki product.
- R4: The integral term is the ki product with its magnitude limited to `il_lim`, which is read as an unsigned value. The sign of the product is kept.
- R5: The derivative interval is `deriv_ivl`+1 samples (1..256). The first sample after reset refreshes the derivative, and so does every sample that follows a full interval. A refresh stores kd times (error minus the previously stored error) and makes the current error the new stored error.
- R6: The most recently refreshed kd product enters the sum on every sample. Samples without a refresh leave it unchanged.
- R7: `cmd_sum` is the proportional product plus the limited integral term plus the derivative term, saturated to a signed 16-bit value.
- R8: With `wide_mode`=0, `cmd_code[7:0]` is `cmd_sum[15:8]` with bit 7 inverted and `cmd_code[11:8]` is 0. With `wide_mode`=1, `cmd_code` is `cmd_sum[15:4]` with bit 11 inverted. A zero sum therefore gives 0x80 or 0x800.
- R9: `err_ready` is high when `cmd_valid` is low or `cmd_ready` is high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_sum` and `cmd_code` hold their values.
- R10: A synchronous `rst` clears the accumulator, the stored error, the interval counter, the held kd product and `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Error sample valid |
| err_ready | output | 1 | Block can accept an error sample |
| err_data | input | 24 | Signed position error |
| kp_coef | input | 16 | Signed proportional coefficient |
| ki_coef | input | 16 | Signed integral coefficient |
| kd_coef | input | 16 | Signed derivative coefficient |
| il_lim | input | 16 | Unsigned limit on the integral term magnitude |
| deriv_ivl | input | 8 | Derivative interval minus one, in samples |
| wide_mode | input | 1 | 0: 8-bit command, 1: 12-bit command |
| cmd_valid | output | 1 | Result valid |
| cmd_ready | input | 1 | Consumer accepts the result |
| cmd_sum | output | 16 | Saturated signed control sum |
| cmd_code | output | 12 | Offset-binary motor command |

## Verification
The bench sweeps interval settings, both width modes and several coefficient sets with errors that step past the 16-bit range. A design that wrapped the input instead of saturating it would give sums of the wrong sign. The bench holds a full-scale error long enough to drive the accumulator into both of its 24-bit limits. A wrapping accumulator would flip the integral term at that point. Other tests set a large ki against a small limit and use intervals greater than one. These expose a missing clamp or a lost sign, and a derivative that is refreshed every sample or dropped between refreshes. A stalled consumer and a reset in the middle of a run check that the pending result is held and that no integral or derivative history survives the reset.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int WORD_W = 16;
  localparam logic signed [31:0] WORD_MAX = 32'sd32767;
  localparam logic signed [31:0] WORD_MIN = -32'sd32768;

  typedef logic signed [WORD_W-1:0] word_t;

  function automatic word_t sat_word(input logic signed [31:0] v);
    if (v > WORD_MAX)      return word_t'(WORD_MAX);
    else if (v < WORD_MIN) return word_t'(WORD_MIN);
    else                   return word_t'(v);
  endfunction
endpackage

// File: rtl/pid_integ.sv
module pid_integ #(
  parameter int D_W   = 16,
  parameter int ACC_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic signed [D_W-1:0] err_s,
  input  logic        [D_W-1:0] ki,
  input  logic        [D_W-1:0] il,
  output logic signed [D_W:0]   ki_term
);
  localparam int SUM_W = ACC_W + 1;

  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic signed [SUM_W-1:0] acc_sum;
  logic        [D_W-1:0]   ki_op, prod;
  logic signed [D_W:0]     prod_x, mag, lim;

  always_comb begin
    acc_sum = {acc_q[ACC_W-1], acc_q} + {{(SUM_W-D_W){err_s[D_W-1]}}, err_s};
    if (acc_sum[SUM_W-1] != acc_sum[SUM_W-2])
      acc_nx = acc_sum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      acc_nx = acc_sum[ACC_W-1:0];
    ki_op   = acc_nx[ACC_W-1 -: D_W];
    prod    = ki_op * ki;
    prod_x  = {prod[D_W-1], prod};
    mag     = prod[D_W-1] ? -prod_x : prod_x;
    lim     = (mag > $signed({1'b0, il})) ? $signed({1'b0, il}) : mag;
    ki_term = prod[D_W-1] ? -lim : lim;
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (fire) acc_q <= acc_nx;
  end

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(acc_q)); // R3
endmodule

// File: rtl/pid_deriv.sv
module pid_deriv #(
  parameter int D_W   = 16,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic signed [D_W-1:0] err_s,
  input  logic        [D_W-1:0] kd,
  input  logic        [CNT_W-1:0] ivl,
  output logic signed [D_W-1:0] kd_term
);
  logic [CNT_W-1:0] cnt_q;
  logic [D_W-1:0]   prev_q, kd_q, diff, prod;
  logic             refresh;

  always_comb begin
    refresh = (cnt_q == '0);
    diff    = err_s - prev_q;
    prod    = diff * kd;
    kd_term = refresh ? prod : kd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= '0;
      kd_q   <= '0;
    end else if (fire) begin
      if (refresh) begin
        cnt_q  <= ivl;
        prev_q <= err_s;
        kd_q   <= prod;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  AST_KD_KEEP: assert property (@(posedge clk) disable iff (rst)
    fire && (cnt_q != '0) |=> $stable(kd_q) && $stable(prev_q)); // R6
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    fire && (cnt_q == '0) |=> cnt_q == $past(ivl)); // R5
endmodule

// File: rtl/pid_clamp_filter.sv
module pid_clamp_filter
  import pid_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int ACC_W = 24,
  parameter int CNT_W = 8,
  parameter int CMD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [IN_W-1:0]  err_data,
  input  logic [15:0]      kp_coef,
  input  logic [15:0]      ki_coef,
  input  logic [15:0]      kd_coef,
  input  logic [15:0]      il_lim,
  input  logic [CNT_W-1:0] deriv_ivl,
  input  logic             wide_mode,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [15:0]      cmd_sum,
  output logic [CMD_W-1:0] cmd_code
);
  localparam int D_W   = WORD_W;
  localparam int NAR_W = 8;
  localparam int TOT_W = D_W + 3;

  logic              fire;
  word_t             err_s, sum_sat;
  logic [D_W-1:0]    kp_prod;
  logic signed [D_W:0]   ki_term, ki_mag;
  word_t             kd_term;
  logic signed [TOT_W-1:0] total;
  logic [CMD_W-1:0]  code_nx;

  assign err_ready = !cmd_valid || cmd_ready;
  assign fire      = err_valid && err_ready;

  always_comb begin
    err_s   = sat_word(32'(signed'(err_data)));
    kp_prod = err_s * kp_coef;
    total   = TOT_W'(signed'(kp_prod)) + TOT_W'(ki_term) + TOT_W'(kd_term);
    sum_sat = sat_word(32'(total));
    if (wide_mode)
      code_nx = {~sum_sat[D_W-1], sum_sat[D_W-2 -: CMD_W-1]};
    else
      code_nx = {{(CMD_W-NAR_W){1'b0}}, ~sum_sat[D_W-1], sum_sat[D_W-2 -: NAR_W-1]};
    ki_mag  = ki_term[D_W] ? -ki_term : ki_term;
  end

  pid_integ #(.D_W(D_W), .ACC_W(ACC_W)) integ_i (
    .clk(clk), .rst(rst), .fire(fire), .err_s(err_s),
    .ki(ki_coef), .il(il_lim), .ki_term(ki_term)
  );

  pid_deriv #(.D_W(D_W), .CNT_W(CNT_W)) deriv_i (
    .clk(clk), .rst(rst), .fire(fire), .err_s(err_s),
    .kd(kd_coef), .ivl(deriv_ivl), .kd_term(kd_term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_sum   <= '0;
      cmd_code  <= '0;
    end else if (fire) begin
      cmd_valid <= 1'b1;
      cmd_sum   <= sum_sat;
      cmd_code  <= code_nx;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  AST_KI_BOUND: assert property (@(posedge clk) disable iff (rst)
    fire |-> ki_mag <= $signed({1'b0, il_lim})); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_sum) && $stable(cmd_code)); // R9
endmodule

// File: tb/pid_clamp_filter_tb_top.sv
module pid_clamp_filter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic err_ready;
  logic [23:0] err_data = '0;
  logic [15:0] kp = '0, ki = '0, kd = '0, il = '0;
  logic [7:0]  ivl = '0;
  logic wide = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [15:0] cmd_sum;
  logic [11:0] cmd_code;

  int n_chk = 0, n_err = 0;
  longint m_acc, m_prev, m_kd;
  int m_cnt;
  logic [15:0] e_sum;
  logic [11:0] e_code;

  always #5ns clk = ~clk;

  pid_clamp_filter dut_i (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .kp_coef(kp), .ki_coef(ki), .kd_coef(kd),
    .il_lim(il), .deriv_ivl(ivl), .wide_mode(wide), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_sum(cmd_sum), .cmd_code(cmd_code)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lo16(longint a, longint b);
    longint p = (a * b) & 64'hFFFF;
    if (p >= 32768) p -= 65536;
    return p;
  endfunction

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic model_reset();
    m_acc = 0; m_prev = 0; m_kd = 0; m_cnt = 0;
  endtask

  task automatic model_step(longint e_in);
    longint es, p, mag, lim, kit, s;
    es    = clampv(e_in, -32768, 32767);
    m_acc = clampv(m_acc + es, -8388608, 8388607);
    p     = lo16(m_acc >>> 8, longint'($signed(ki)));
    mag   = (p < 0) ? -p : p;
    lim   = (mag > longint'(il)) ? longint'(il) : mag;
    kit   = (p < 0) ? -lim : lim;
    if (m_cnt == 0) begin
      m_kd   = lo16(es - m_prev, longint'($signed(kd)));
      m_prev = es;
      m_cnt  = int'(ivl);
    end else m_cnt--;
    s      = clampv(lo16(es, longint'($signed(kp))) + kit + m_kd, -32768, 32767);
    e_sum  = 16'(s);
    if (wide) e_code = {~e_sum[15], e_sum[14:4]};
    else      e_code = {4'h0, ~e_sum[15], e_sum[14:8]};
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  task automatic sample(longint e_in, string tag);
    model_step(e_in);
    @(negedge clk);
    err_data  = 24'(e_in);
    err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    check({tag, " valid"}, cmd_valid, 1);
    check({tag, " sum"}, longint'($signed(cmd_sum)), longint'($signed(e_sum)));
    check({tag, " code"}, cmd_code, e_code);
  endtask

  task automatic set_coef(int a, int b, int c, int d);
    kp = 16'(a); ki = 16'(b); kd = 16'(c); il = 16'(d);
  endtask

  initial begin
    #2ms;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int ivls[4] = '{0, 1, 2, 5};
    logic [15:0] held;
    do_reset();
    // R10: reset state
    check("R10 reset cmd_valid", cmd_valid, 0);
    check("R9 ready after reset", err_ready, 1);

    // R1: input saturation with unit kp
    set_coef(1, 0, 0, 0);
    sample(100000, "R1 pos");
    sample(-100000, "R1 neg");
    sample(-32768, "R1 edge");
    // R2: low 16 bits of product
    set_coef(300, 0, 0, 0);
    sample(300, "R2 trunc");

    // R7 R8: sweep modes, intervals and coefficient sets
    for (int md = 0; md < 2; md++)
      for (int iv = 0; iv < 4; iv++)
        for (int cs = 0; cs < 3; cs++) begin
          wide = md[0]; ivl = 8'(ivls[iv]);
          case (cs)
            0: set_coef(3, 40, -7, 2000);
            1: set_coef(-120, 900, 55, 300);
            default: set_coef(900, -25000, 2500, 65535);
          endcase
          do_reset();
          for (int k = 0; k < 24; k++)
            sample(longint'((k * 7919 + cs * 131) % 80001) - 40000, "R7 R8 sweep");
        end

    // R4: strong ki against a small limit, both signs
    wide = 1'b1; ivl = 0;
    set_coef(0, 30000, 0, 100);
    do_reset();
    for (int k = 0; k < 12; k++) sample((k < 6) ? 20000 : -30000, "R4 clamp");

    // R5 R6: derivative refreshed every 4th sample, held between
    set_coef(0, 0, 1, 0); ivl = 3;
    do_reset();
    for (int k = 0; k < 14; k++) sample(k * k * 37 - 500, "R5 R6 hold");

    // R3: drive accumulator into both saturation limits
    set_coef(0, 1, 0, 65535); ivl = 0;
    do_reset();
    for (int k = 0; k < 300; k++) sample(50000, "R3 acc high");
    for (int k = 0; k < 600; k++) sample(-50000, "R3 acc low");

    // R9: stalled consumer holds the result and blocks input
    set_coef(5, 0, 0, 0);
    do_reset();
    cmd_ready = 1'b0;
    sample(1000, "R9 first");
    held = cmd_sum;
    @(negedge clk); err_data = 24'(2000); err_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 ready low", err_ready, 0);
      check("R9 sum held", cmd_sum, held);
    end
    model_step(2000);
    cmd_ready = 1'b1;
    @(negedge clk); err_valid = 1'b0;
    check("R9 after release", longint'($signed(cmd_sum)), longint'($signed(e_sum)));

    // R10: reset mid-run clears history
    set_coef(2, 500, 300, 65535); ivl = 2;
    for (int k = 0; k < 5; k++) sample(9000, "R10 prerun");
    do_reset();
    check("R10 valid cleared", cmd_valid, 0);
    sample(1234, "R10 after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule